// File: doc/BRIEF.md
# Byte-Wide PCM Channel Deinterleaver

This block sits behind an 8-bit parallel host port. It turns a stream of single-byte PCM writes into complete audio sample words, each tagged with the channel it belongs to. The host writes the bytes of each sample one after another, channel by channel. The block packs each group of bytes into one sample, most significant byte first. When the last byte of a sample arrives, it issues the finished word together with a channel index for the processing logic downstream.

The number of bytes per sample (one to three) and the number of interleaved channels (one to eight) are set at run time through configuration inputs. A resync control gives software a way to realign. While the control is high, the port ignores data and holds its byte and channel position at zero. Once the control returns low, the next accepted byte is the first byte of channel 0, which is the left channel.

Top module: `pcm_byte_deinterleaver`

## Requirements
- R1: A byte is accepted only in a cycle where `wr_en` is high, `wr_addr` equals 2'b10 and `resync` is low. Writes to any other address have no effect on the output or on the packing position.
- R2: A sample is packed most significant byte first and is right-justified in the 24-bit `smp_data`. For a one-byte sample the word is {16'h0, byte}. For a two-byte sample it is {8'h0, first, second}. For a three-byte sample it is {first, second, third}.
- R3: `smp_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the last byte of a sample. It stays low after every other byte.
- R4: `cfg_bytes` gives the number of bytes per sample: 1, 2 or 3. The value 0 is treated as 1.
- R5: The channel count is `cfg_chans`+1. `smp_chan` starts at 0, rises by one per completed sample and returns to 0 after channel `cfg_chans`.
- R6: While `resync` is high, data writes are ignored and no sample is produced. After `resync` falls, the next accepted byte is the first byte of a channel 0 sample, and any partly collected sample is discarded.
- R7: With one byte and two channels, accepted bytes alternate between channel 0 (left) and channel 1 (right). With two bytes and two channels, bytes one and two form the left sample and bytes three and four form the right sample.
- R8: After reset `smp_valid` is low, and the first accepted byte starts a channel 0 sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_addr | input | 2 | Host register address; 2'b10 selects the PCM data port |
| wr_data | input | 8 | Host write byte |
| resync | input | 1 | Realign control; high holds the position at channel 0, byte 0 |
| cfg_bytes | input | 2 | Bytes per sample, 1 to 3 (0 acts as 1) |
| cfg_chans | input | 3 | Channel count minus one |
| smp_valid | output | 1 | One-cycle pulse marking a finished sample |
| smp_data | output | 24 | Finished sample, right-justified |
| smp_chan | output | 3 | Channel index of the finished sample |

## Verification
Two functions can meet in one clock cycle. One is a data-port write, possibly carrying the last byte of a sample. The other is an asserted resync. The bench provokes this collision in two ways: directly, by raising resync in the same cycle as a sample's final byte, and randomly, by driving writes throughout every resync window. The cycle is judged correct only if no sample pulse follows it, and only if the next accepted byte after resync falls starts a fresh channel 0 sample with no trace of the discarded bytes.

// File: rtl/pcm_byte_deinterleaver.sv
module pcm_byte_deinterleaver #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 3,
  parameter int MAX_CH    = 8,
  parameter logic [1:0] DATA_ADDR = 2'b10,
  localparam int SW   = BYTE_W * MAX_BYTES,
  localparam int CH_W = $clog2(MAX_CH),
  localparam int BW   = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              resync,
  input  logic [BW-1:0]     cfg_bytes,
  input  logic [CH_W-1:0]   cfg_chans,
  output logic              smp_valid,
  output logic [SW-1:0]     smp_data,
  output logic [CH_W-1:0]   smp_chan
);

  logic [BW-1:0]   bcnt;
  logic [CH_W-1:0] ccnt;
  logic [SW-1:0]   acc;

  logic            take;
  logic [BW-1:0]   nbytes;
  logic            last_byte;
  logic [CH_W-1:0] cur_ch;
  logic [SW-1:0]   base;
  logic [SW-1:0]   packed_w;

  assign take      = wr_en && (wr_addr == DATA_ADDR) && !resync;
  assign nbytes    = (cfg_bytes == '0) ? BW'(1) :
                     (cfg_bytes > BW'(MAX_BYTES)) ? BW'(MAX_BYTES) : cfg_bytes;
  assign last_byte = (bcnt >= nbytes - BW'(1));
  assign cur_ch    = (ccnt > cfg_chans) ? '0 : ccnt;
  assign base      = (bcnt == '0) ? '0 : acc;
  assign packed_w  = {base[SW-BYTE_W-1:0], wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      ccnt <= '0;
      acc  <= '0;
    end else if (resync) begin
      bcnt <= '0;
      ccnt <= '0;
      acc  <= '0;
    end else if (take) begin
      acc <= packed_w;
      if (last_byte) begin
        bcnt <= '0;
        ccnt <= (cur_ch == cfg_chans) ? '0 : cur_ch + CH_W'(1);
      end else begin
        bcnt <= bcnt + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_chan  <= '0;
    end else begin
      smp_valid <= take && last_byte;
      if (take && last_byte) begin
        smp_data <= packed_w;
        smp_chan <= cur_ch;
      end
    end
  end

  p_resync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !smp_valid);

  p_addr_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == DATA_ADDR) |=> !smp_valid);

  p_chan_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $stable(cfg_chans)) |-> smp_chan <= cfg_chans);

  p_one_byte_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(cfg_bytes) <= BW'(1)) |-> smp_data[SW-1:BYTE_W] == '0);

  p_two_byte_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(cfg_bytes) == BW'(2)) |-> smp_data[SW-1:2*BYTE_W] == '0);

endmodule

// File: tb/pcm_byte_deinterleaver_tb_top.sv
`timescale 1ns/1ps
module pcm_byte_deinterleaver_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, resync = 0;
  logic [1:0] wr_addr = 0, cfg_bytes = 1;
  logic [7:0] wr_data = 0;
  logic [2:0] cfg_chans = 1;
  logic smp_valid;
  logic [23:0] smp_data;
  logic [2:0] smp_chan;

  int n_run = 0, n_fail = 0;
  int m_b = 0, m_c = 0;
  logic [23:0] m_acc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_byte_deinterleaver dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .resync(resync), .cfg_bytes(cfg_bytes),
    .cfg_chans(cfg_chans), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan));

  function automatic int nb_of(logic [1:0] b);
    return (b == 0) ? 1 : int'(b);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(bit we, logic [1:0] a, logic [7:0] d, bit rs, string tag);
    bit exp_v = 0;
    logic [23:0] exp_d = 0;
    int exp_c = 0;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; resync = rs;
    if (rs) begin
      m_b = 0; m_c = 0; m_acc = 0;
    end else if (we && a == 2'b10) begin
      m_acc = ((m_b == 0) ? 24'h0 : m_acc) << 8 | {16'h0, d};
      if (m_b == nb_of(cfg_bytes) - 1) begin
        exp_v = 1; exp_d = m_acc; exp_c = m_c;
        m_b = 0;
        m_c = (m_c == int'(cfg_chans)) ? 0 : m_c + 1;
      end else m_b++;
    end
    @(negedge clk);
    wr_en = 0; resync = 0;
    check(smp_valid == exp_v, {tag, " valid"}, 32'(smp_valid), 32'(exp_v));
    if (exp_v) begin
      check(smp_data == exp_d, {tag, " data"}, 32'(smp_data), 32'(exp_d));
      check(int'(smp_chan) == exp_c, {tag, " chan"}, 32'(smp_chan), 32'(exp_c));
    end
  endtask

  task automatic wr(logic [7:0] d, string tag);
    op(1, 2'b10, d, 0, tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(smp_valid == 0, "R8 reset valid", 32'(smp_valid), 0);
    rst_n = 1;
    // R7 R8: 8-bit stereo alternation from reset
    cfg_bytes = 1; cfg_chans = 1;
    wr(8'h11, "R8 first L"); wr(8'h22, "R7 R");
    wr(8'h33, "R7 L"); wr(8'h44, "R7 R");
    // R1: other addresses ignored
    op(1, 2'b00, 8'hAA, 0, "R1 addr0");
    op(1, 2'b11, 8'hBB, 0, "R1 addr3");
    op(1, 2'b01, 8'hCC, 0, "R1 addr1");
    wr(8'h55, "R1 next L");
    wr(8'h66, "R1 next R");
    // R7: 16-bit stereo after resync
    cfg_bytes = 2;
    op(0, 2'b10, 0, 1, "R6 pulse");
    wr(8'h12, "R7 L hi"); wr(8'h34, "R7 L lo");
    wr(8'h56, "R7 R hi"); wr(8'h78, "R7 R lo");
    // R6: resync mid-sample discards partial bytes
    wr(8'h9A, "R6 partial");
    op(1, 2'b10, 8'hEE, 1, "R6 write during resync");
    op(1, 2'b10, 8'hEF, 1, "R6 held");
    wr(8'hAB, "R6 fresh hi"); wr(8'hCD, "R6 fresh lo");
    // R6: last byte of sample in same cycle as resync
    wr(8'h01, "R6 collide hi");
    op(1, 2'b10, 8'h02, 1, "R6 collide last");
    wr(8'h03, "R6 after hi"); wr(8'h04, "R6 after lo");
    // R2 R5: 24-bit, 3 channels wrap
    cfg_bytes = 3; cfg_chans = 2;
    op(0, 2'b10, 0, 1, "R6 pulse");
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 3; k++) wr(8'(s * 16 + k + 1), "R2 R5 24bit");
    // R4: zero treated as one byte, mono
    cfg_bytes = 0; cfg_chans = 0;
    op(0, 2'b10, 0, 1, "R6 pulse");
    wr(8'hF0, "R4 zero width"); wr(8'hF1, "R4 zero width");
    // R5: eight channels wrap
    cfg_bytes = 1; cfg_chans = 7;
    op(0, 2'b10, 0, 1, "R6 pulse");
    for (int k = 0; k < 10; k++) wr(8'(k), "R5 8ch");
    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      cfg_bytes = 2'($urandom_range(0, 3));
      cfg_chans = 3'($urandom_range(0, 7));
      for (int k = 0; k < int'($urandom_range(1, 3)); k++)
        op(1'($urandom), 2'($urandom), 8'($urandom), 1, "R6 random resync");
      for (int k = 0; k < 80; k++) begin
        logic [1:0] a = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b10;
        op(1'($urandom_range(0, 4) != 0), a, 8'($urandom), 0, "R3 random");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule